// File: doc/BRIEF.md
# Multi-Mode Prescaled Timer

This block is a count-down divider chain. An 8-bit prescaler feeds an 8-bit timer. Each stage has its own reload latch and divides its input by n+1, where n is the latch value. Whenever the timer steps past zero it reloads from its latch and raises an interrupt pulse.

A two-bit mode field decides what the chain counts and what it does with the external counter pin.
- In plain timing, the chain counts an internal tick.
- In pulse generation, it toggles the pin output on every timer underflow.
- In event counting, it counts edges on the pin and bypasses the prescaler.
- In width measurement, it counts the internal tick only while the pin sits at a chosen level.

One polarity bit sets all of the pin-related senses at once: the counted edge, the edge that raises the pin interrupt, the start level of the generated waveform and the measured level. A second bit picks the internal tick: one sixteenth or one half of the system clock.

Software loads the latches through a simple write port and reads the running counters through a read port. A stop input freezes both counters. While the chain is stopped, a latch write also loads the matching counter.

Top module: `mm_prescaled_timer`

## Requirements
- R1: After reset, tmr_irq and cntr_irq are 0, cntr_out is 1, cntr_oe is 0 and both counters read 0.
- R2: Each stage counts down once per input pulse and, at 0, reloads its latch on the next pulse. In timing mode with the half-rate tick, prescaler latch p and timer latch t, underflows are 2*(p+1)*(t+1) clocks apart.
- R3: An underflow raises tmr_irq for exactly one clock, in the cycle after the count pulse that found the timer at 0. The counter then holds the latch value.
- R4: mode encodes 00 timing, 01 pulse generation, 10 event counting and 11 width measurement. cntr_oe is 1 only in mode 01.
- R5: In mode 01, cntr_out inverts on every timer underflow. A timer latch write sets cntr_out to 1 when edge_sel is 0 and to 0 when edge_sel is 1.
- R6: In mode 10 the timer decrements on rising pin edges when edge_sel is 0 and on falling edges when it is 1. The decrement is visible three clocks after the pin changes, because the pin is synchronized through two flops.
- R7: cntr_irq pulses for one clock on falling pin edges when edge_sel is 0 and on rising edges when it is 1, in every mode, three clocks after the pin changes.
- R8: In mode 11 the internal tick reaches the prescaler only while the synchronized pin is high (edge_sel 0) or low (edge_sel 1).
- R9: src_fast 0 selects a tick every 16 clocks; src_fast 1 selects a tick every 2 clocks.
- R10: While stop is 1, neither counter changes except through a latch write.
- R11: wr_sel 0 addresses the prescaler and 1 addresses the timer; rd_sel picks the counter the same way. A write while stop is 1 loads both latch and counter. A write while stop is 0 updates only the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Latch write strobe |
| wr_sel | input | 1 | Write target: 0 prescaler, 1 timer |
| wr_data | input | 8 | Latch write value |
| rd_sel | input | 1 | Read source: 0 prescaler counter, 1 timer counter |
| rd_data | output | 8 | Selected counter value |
| mode | input | 2 | Operating mode |
| edge_sel | input | 1 | Pin polarity for counting, interrupt, start level and measured level |
| stop | input | 1 | Freeze counting |
| src_fast | input | 1 | Internal tick select |
| cntr_in | input | 1 | Counter pin input (asynchronous) |
| cntr_out | output | 1 | Generated waveform |
| cntr_oe | output | 1 | Drive enable for cntr_out |
| tmr_irq | output | 1 | Timer underflow pulse |
| cntr_irq | output | 1 | Pin edge interrupt pulse |

## Verification
A write is visible on rd_data at the first falling edge after the clock edge that takes it. A pin change reaches the timer count and cntr_irq on the third rising edge. tmr_irq appears one edge after the counting pulse that finds zero, and cntr_out toggles on that same edge. The bench drives inputs on falling edges and samples on falling edges, so it reads the exact cycle counts above. Underflow spacing is measured between two tmr_irq pulses rather than from a start point, because the internal tick divider runs freely and its phase is not known.

// File: rtl/mm_prescaled_timer.sv
module mm_prescaled_timer #(
  parameter int W        = 8,
  parameter int SLOW_DIV = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  input  logic [1:0]   mode,
  input  logic         edge_sel,
  input  logic         stop,
  input  logic         src_fast,
  input  logic         cntr_in,
  output logic         cntr_out,
  output logic         cntr_oe,
  output logic         tmr_irq,
  output logic         cntr_irq
);
  localparam int DW = $clog2(SLOW_DIV);
  localparam logic [1:0] M_TIME = 2'b00, M_PULSE = 2'b01, M_EVENT = 2'b10, M_WIDTH = 2'b11;

  logic [DW-1:0] div;
  logic [2:0]    sy;
  logic [W-1:0]  pre_lat, pre_cnt, tm_lat, tm_cnt;
  logic          tog;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div <= '0;
    else        div <= div + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], cntr_in};

  wire pin      = sy[1];
  wire rise     = sy[1] & ~sy[2];
  wire fall     = ~sy[1] & sy[2];
  wire cnt_edge = edge_sel ? fall : rise;
  wire irq_edge = edge_sel ? rise : fall;
  wire level_ok = pin ^ edge_sel;

  wire src_tick = src_fast ? div[0] : (div == DW'(SLOW_DIV - 1));
  wire pre_en   = ~stop & src_tick &
                  ((mode == M_TIME) | (mode == M_PULSE) | ((mode == M_WIDTH) & level_ok));
  wire pre_uf   = pre_en & (pre_cnt == '0);
  wire tm_en    = ~stop & ((mode == M_EVENT) ? cnt_edge : pre_uf);
  wire tm_uf    = tm_en & (tm_cnt == '0);
  wire wr_pre   = wr_en & ~wr_sel;
  wire wr_tm    = wr_en & wr_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_lat <= '0;
      pre_cnt <= '0;
    end else begin
      if (wr_pre) pre_lat <= wr_data;
      if (wr_pre && stop) pre_cnt <= wr_data;
      else if (pre_en)    pre_cnt <= pre_uf ? pre_lat : pre_cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tm_lat <= '0;
      tm_cnt <= '0;
    end else begin
      if (wr_tm) tm_lat <= wr_data;
      if (wr_tm && stop) tm_cnt <= wr_data;
      else if (tm_en)    tm_cnt <= tm_uf ? tm_lat : tm_cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tog      <= 1'b1;
      tmr_irq  <= 1'b0;
      cntr_irq <= 1'b0;
    end else begin
      if (wr_tm)                        tog <= ~edge_sel;
      else if (tm_uf && mode == M_PULSE) tog <= ~tog;
      tmr_irq  <= tm_uf;
      cntr_irq <= irq_edge;
    end

  assign cntr_out = tog;
  assign cntr_oe  = (mode == M_PULSE);
  assign rd_data  = rd_sel ? tm_cnt : pre_cnt;

  AST_UF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tm_uf |=> (tm_cnt == $past(tm_lat))); // R2
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq |=> !tmr_irq); // R3
  AST_PULSE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_uf && mode == M_PULSE && !wr_tm) |=> (cntr_out != $past(cntr_out))); // R5
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_en) |=> ($stable(tm_cnt) && $stable(pre_cnt))); // R10
endmodule

// File: tb/mm_prescaled_timer_tb_top.sv
module mm_prescaled_timer_tb_top;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [1:0] mode = 0;
  logic       edge_sel = 0, stop = 1, src_fast = 1, cntr_in = 0;
  logic       cntr_out, cntr_oe, tmr_irq, cntr_irq;
  int checks = 0, fails = 0;
  int cyc = 0, uf_cnt = 0, last_uf = 0, prev_uf = 0, ci_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mm_prescaled_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .mode(mode), .edge_sel(edge_sel), .stop(stop),
    .src_fast(src_fast), .cntr_in(cntr_in), .cntr_out(cntr_out), .cntr_oe(cntr_oe),
    .tmr_irq(tmr_irq), .cntr_irq(cntr_irq));

  always @(negedge clk) begin
    cyc++;
    if (tmr_irq) begin prev_uf = last_uf; last_uf = cyc; uf_cnt++; end
    if (cntr_irq) ci_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input bit sel, output int v);
    rd_sel = sel; #1 v = rd_data;
  endtask

  task automatic wait_uf(input int n);
    int target = uf_cnt + n;
    for (int i = 0; i < 5000 && uf_cnt < target; i++) @(negedge clk);
  endtask

  task automatic pin_pulse();
    @(negedge clk); cntr_in = 1; repeat (4) @(negedge clk);
    cntr_in = 0; repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    @(negedge clk);
    check(tmr_irq == 0 && cntr_irq == 0, "R1 irqs", tmr_irq + cntr_irq, 0);
    check(cntr_out == 1, "R1 cntr_out", cntr_out, 1);
    check(cntr_oe == 0, "R1 cntr_oe", cntr_oe, 0);
    rd(1, v); check(v == 0, "R1 timer count", v, 0);
  endtask

  task automatic t_write();
    int v;
    stop = 1; mode = 2'b10;
    wr(1, 8'h5A); wr(0, 8'h33);
    rd(1, v); check(v == 8'h5A, "R11 stopped timer write loads counter", v, 8'h5A);
    rd(0, v); check(v == 8'h33, "R11 stopped prescaler write loads counter", v, 8'h33);
    stop = 0;
    wr(1, 8'h10);
    repeat (3) @(negedge clk);
    rd(1, v); check(v == 8'h5A, "R11 running write leaves counter", v, 8'h5A);
  endtask

  task automatic t_event();
    int v, u0, c0;
    stop = 1; mode = 2'b10; edge_sel = 0;
    wr(1, 8'd2); stop = 0;
    u0 = uf_cnt; c0 = ci_cnt;
    @(negedge clk); cntr_in = 1;
    @(negedge clk); @(negedge clk);
    rd(1, v); check(v == 2, "R6 no count before sync delay", v, 2);
    @(negedge clk);
    rd(1, v); check(v == 1, "R6 count on third edge", v, 1);
    repeat (3) @(negedge clk); cntr_in = 0; repeat (4) @(negedge clk);
    rd(1, v); check(v == 1, "R6 falling edge not counted with edge_sel 0", v, 1);
    check(ci_cnt - c0 == 1, "R7 irq on falling edge with edge_sel 0", ci_cnt - c0, 1);
    pin_pulse();
    rd(1, v); check(v == 0, "R6 second rising edge", v, 0);
    check(uf_cnt == u0, "R3 no underflow yet", uf_cnt - u0, 0);
    pin_pulse();
    rd(1, v); check(v == 2, "R3 reload after underflow", v, 2);
    check(uf_cnt - u0 == 1, "R3 one underflow pulse", uf_cnt - u0, 1);
    edge_sel = 1; c0 = ci_cnt;
    @(negedge clk); cntr_in = 1; repeat (4) @(negedge clk);
    rd(1, v); check(v == 2, "R6 rising edge not counted with edge_sel 1", v, 2);
    check(ci_cnt - c0 == 1, "R7 irq on rising edge with edge_sel 1", ci_cnt - c0, 1);
    cntr_in = 0; repeat (4) @(negedge clk);
    rd(1, v); check(v == 1, "R6 falling edge counted with edge_sel 1", v, 1);
    check(ci_cnt - c0 == 1, "R7 no irq on falling with edge_sel 1", ci_cnt - c0, 1);
    edge_sel = 0;
  endtask

  task automatic t_period();
    stop = 1; mode = 2'b00; src_fast = 1;
    wr(0, 8'd1); wr(1, 8'd2); stop = 0;
    check(cntr_oe == 0, "R4 no drive in timing mode", cntr_oe, 0);
    wait_uf(3);
    check(last_uf - prev_uf == 12, "R2 half-rate period", last_uf - prev_uf, 12);
    stop = 1; src_fast = 0;
    wr(0, 8'd0); wr(1, 8'd1); stop = 0;
    wait_uf(3);
    check(last_uf - prev_uf == 32, "R9 slow tick period", last_uf - prev_uf, 32);
  endtask

  task automatic t_stop();
    int v0, v1, u0;
    stop = 1; src_fast = 1;
    wr(0, 8'd0); wr(1, 8'd40); stop = 0;
    repeat (10) @(negedge clk);
    stop = 1; @(negedge clk);
    rd(1, v0); u0 = uf_cnt;
    repeat (100) @(negedge clk);
    rd(1, v1);
    check(v1 == v0, "R10 counter frozen", v1, v0);
    check(uf_cnt == u0, "R10 no underflow while stopped", uf_cnt - u0, 0);
  endtask

  task automatic t_pulse();
    stop = 1; mode = 2'b01; edge_sel = 0; src_fast = 1;
    wr(0, 8'd0); wr(1, 8'd3);
    check(cntr_out == 1 && cntr_oe == 1, "R5 start high, R4 drive on", cntr_out, 1);
    stop = 0;
    wait_uf(1);
    check(cntr_out == 0, "R5 toggle on first underflow", cntr_out, 0);
    wait_uf(1);
    check(cntr_out == 1, "R5 toggle on second underflow", cntr_out, 1);
    stop = 1; edge_sel = 1;
    wr(1, 8'd3);
    check(cntr_out == 0, "R5 start low with edge_sel 1", cntr_out, 0);
    edge_sel = 0;
  endtask

  task automatic t_width();
    int v;
    stop = 1; mode = 2'b11; edge_sel = 0; src_fast = 1; cntr_in = 0;
    wr(0, 8'd0); wr(1, 8'd200); stop = 0;
    repeat (50) @(negedge clk);
    rd(1, v); check(v == 200, "R8 no count while pin low", v, 200);
    cntr_in = 1; repeat (40) @(negedge clk); cntr_in = 0;
    repeat (10) @(negedge clk);
    rd(1, v); check(v == 180, "R8 counted 20 ticks while high", v, 180);
    edge_sel = 1; repeat (20) @(negedge clk);
    rd(1, v); check(v < 180, "R8 counts while low with edge_sel 1", v, 170);
    stop = 1; edge_sel = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write();
    t_event();
    t_period();
    t_stop();
    t_pulse();
    t_width();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule